// File: doc/BRIEF.md
# Signed-Offset Bit Window Extractor

This combinational block reads a window of bits out of a data word. Output bit `i` is taken from input bit `i + offset`. The offset may be treated as signed, so the window can slide toward either end of the input. Output positions whose source index falls outside the input word are filled.

A mode input selects how filled positions are reported:

- **Zero mode:** the bits read as zero and nothing else is marked.
- **Marker mode:** a per-bit mask flags every output position that was filled rather than read from the input.

A qualifier input declares the offset itself unknown. In that case the whole result is declared invalid through a validity flag, and every mask bit is raised. This replaces the X propagation of four-valued simulation.

Typical use is a barrel-style field extractor in a datapath, where a later stage needs to know which result bits are real data.

The data width, offset width, output width and offset signedness are parameters. The output width defaults to the data width.

Top module: `bit_window`

## Requirements
- R1: With a known offset, every output bit `y_out[i]` whose source index `i + offset` lies in `0 .. A_W-1` equals `a_in[i + offset]`.
- R2: When `SIGNED_OFF` is 1, `off_in` is read as two's complement, so an all-ones offset means -1 and output bit `i` reads input bit `i-1`.
- R3: When `SIGNED_OFF` is 0, `off_in` is read as unsigned, so an all-ones offset is the largest positive shift.
- R4: An output bit whose source index is negative, or is `A_W` or more, reads 0 in both fill modes.
- R5: With `fill_mode` = 1 (marker mode) and a known offset, `fill_mask[i]` is 1 exactly for the output bits covered by R4 and 0 for bits covered by R1.
- R6: With `fill_mode` = 0 (zero mode) and a known offset, `fill_mask` is all zeros.
- R7: When `off_unknown` is 1, `y_ok` is 0, `y_out` is all zeros and `fill_mask` is all ones, whatever the other inputs are. When `off_unknown` is 0, `y_ok` is 1.
- R8: When `Y_W` is not overridden, the output width equals `A_W`. An overridden `Y_W` larger than `A_W` is honoured, with the upper positions filled.
- R9: The outputs are a pure function of the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | A_W | Source data word |
| off_in | input | B_W | Shift offset, signed or unsigned according to `SIGNED_OFF` |
| off_unknown | input | 1 | Offset is not known; the result is declared invalid |
| fill_mode | input | 1 | 0 = zero fill, unmarked; 1 = zero fill with filled bits marked |
| y_out | output | Y_W | Extracted window |
| fill_mask | output | Y_W | Marks output bits that were filled rather than sourced |
| y_ok | output | 1 | High when the offset is known and `y_out` is meaningful |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between inputs and outputs. The bench changes inputs just after a rising edge and reads `y_out`, `fill_mask` and `y_ok` at the following falling edge. By then the combinational paths have settled, and no result depends on process order at the edge.

A behavioural loop model in the bench computes the expected window for every offset the offset width can express. This includes negative offsets and offsets past the data width. The model is run against a signed instance with the default output width and an unsigned instance with a wider output.

// File: rtl/bit_window.sv
module bit_window #(
  parameter int A_W        = 8,
  parameter int B_W        = 4,
  parameter int Y_W        = A_W,
  parameter bit SIGNED_OFF = 1'b1
) (
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] off_in,
  input  logic           off_unknown,
  input  logic           fill_mode,
  output logic [Y_W-1:0] y_out,
  output logic [Y_W-1:0] fill_mask,
  output logic           y_ok
);

  localparam int AB  = $clog2(A_W + 1);
  localparam int YB  = $clog2(Y_W + 1);
  localparam int M1  = (B_W > AB) ? B_W : AB;
  localparam int IW  = ((M1 > YB) ? M1 : YB) + 2;
  localparam int AIW = (A_W > 1) ? $clog2(A_W) : 1;

  logic [IW-1:0] off_ext;

  generate
    if (SIGNED_OFF) begin : g_sext
      assign off_ext = {{(IW-B_W){off_in[B_W-1]}}, off_in};
    end else begin : g_zext
      assign off_ext = {{(IW-B_W){1'b0}}, off_in};
    end
  endgenerate

  assign y_ok = !off_unknown;

  for (genvar i = 0; i < Y_W; i++) begin : g_bit
    logic [IW-1:0] src;
    logic          hit;
    assign src          = off_ext + IW'(i);
    assign hit          = !src[IW-1] && (src < IW'(A_W));
    assign y_out[i]     = !off_unknown && hit && a_in[src[AIW-1:0]];
    assign fill_mask[i] = off_unknown || (fill_mode && !hit);
  end

  always_comb begin
    // R7
    unknown_fill_chk: assert (!off_unknown || (!y_ok && y_out == '0 && fill_mask == '1));
    // R4
    filled_zero_chk: assert ((y_out & fill_mask) == '0);
    // R6
    zero_mode_mask_chk: assert (off_unknown || fill_mode || fill_mask == '0);
    // R1
    aligned_bit_chk: assert (off_unknown || off_in != '0 || y_out[0] == a_in[0]);
  end

endmodule

// File: tb/bit_window_tb.sv
module bit_window_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0]  a;
  logic [3:0]  off;
  logic        unk;
  logic        mode;
  logic [7:0]  ys, ms;
  logic        oks;
  logic [11:0] yu, mu;
  logic        oku;

  bit_window #(.A_W(8), .B_W(4), .SIGNED_OFF(1'b1)) u_dut (
    .a_in(a), .off_in(off), .off_unknown(unk), .fill_mode(mode),
    .y_out(ys), .fill_mask(ms), .y_ok(oks));

  bit_window #(.A_W(8), .B_W(4), .Y_W(12), .SIGNED_OFF(1'b0)) u_dut_u (
    .a_in(a), .off_in(off), .off_unknown(unk), .fill_mode(mode),
    .y_out(yu), .fill_mask(mu), .y_ok(oku));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] d, input int o, input logic md, input logic uk,
                       input int yw, output logic [31:0] y, output logic [31:0] m);
    y = '0;
    m = '0;
    for (int i = 0; i < yw; i++) begin
      int s = i + o;
      if (uk) m[i] = 1'b1;
      else if (s >= 0 && s < 8) y[i] = d[s];
      else m[i] = md;
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic [3:0] o, input logic uk, input logic md);
    @(posedge clk);
    a = d; off = o; unk = uk; mode = md;
    @(negedge clk);
  endtask

  task automatic t_idle();
    apply(8'h00, 4'h0, 1'b0, 1'b0);
    chk("R9 idle y", {24'h0, ys}, 32'h0);
    chk("R9 idle mask", {24'h0, ms}, 32'h0);
    chk("R7 idle ok", {31'h0, oks}, 32'h1);
  endtask

  task automatic t_signed_sweep(input logic [7:0] d);
    logic [31:0] ey, em;
    for (int md = 0; md < 2; md++)
      for (int o = 0; o < 16; o++) begin
        apply(d, 4'(o), 1'b0, 1'(md));
        model(d, (o >= 8) ? o - 16 : o, 1'(md), 1'b0, 8, ey, em);
        chk(md ? "R1/R2/R4/R5 signed y" : "R1/R2/R4 signed y", {24'h0, ys}, ey);
        chk(md ? "R5 signed mask" : "R6 signed mask", {24'h0, ms}, em);
      end
  endtask

  task automatic t_unsigned_sweep(input logic [7:0] d);
    logic [31:0] ey, em;
    for (int md = 0; md < 2; md++)
      for (int o = 0; o < 16; o++) begin
        apply(d, 4'(o), 1'b0, 1'(md));
        model(d, o, 1'(md), 1'b0, 12, ey, em);
        chk("R1/R3/R4/R8 unsigned y", {20'h0, yu}, ey);
        chk(md ? "R5 unsigned mask" : "R6 unsigned mask", {20'h0, mu}, em);
        chk("R7 known ok", {31'h0, oku}, 32'h1);
      end
  endtask

  task automatic t_corners();
    apply(8'hA5, 4'hF, 1'b0, 1'b1);
    chk("R2 minus one y", {24'h0, ys}, 32'h4A);
    chk("R2 minus one mask", {24'h0, ms}, 32'h01);
    chk("R3 fifteen y", {20'h0, yu}, 32'h0);
    chk("R3 fifteen mask", {20'h0, mu}, 32'hFFF);
    apply(8'hFF, 4'h4, 1'b0, 1'b0);
    chk("R4 zero fill y", {24'h0, ys}, 32'h0F);
    chk("R6 zero fill mask", {24'h0, ms}, 32'h0);
  endtask

  task automatic t_unknown();
    for (int md = 0; md < 2; md++) begin
      apply(8'hFF, 4'h2, 1'b1, 1'(md));
      chk("R7 signed ok", {31'h0, oks}, 32'h0);
      chk("R7 signed y", {24'h0, ys}, 32'h0);
      chk("R7 signed mask", {24'h0, ms}, 32'hFF);
      chk("R7 unsigned ok", {31'h0, oku}, 32'h0);
      chk("R7 unsigned y", {20'h0, yu}, 32'h0);
      chk("R7 unsigned mask", {20'h0, mu}, 32'hFFF);
    end
  endtask

  task automatic t_widths();
    chk("R8 default width", $bits(ys), 32'd8);
    chk("R8 override width", $bits(yu), 32'd12);
  endtask

  initial begin
    a = '0; off = '0; unk = 1'b0; mode = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_widths();
    t_signed_sweep(8'hA5);
    t_signed_sweep(8'h3C);
    t_signed_sweep(8'h81);
    t_unsigned_sweep(8'hC3);
    t_unsigned_sweep(8'h5A);
    t_corners();
    t_unknown();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule